// File: doc/BRIEF.md
# I3C Bus Bit Modulator

This block turns single bus-symbol commands into the SCL and SDA waveforms of an I3C bus. A framing layer above it hands over one symbol at a time (start, repeated start, stop, a written bit in push-pull or open-drain drive, or a read bit) through a valid/ready handshake. The block plays the symbol out and hands back the sampled SDA level for reads, which covers received data, acknowledge and T-bit slots.

Every symbol is cut into eight sub-phases. SCL is low for the first four and high for the last four. SDA may change only in a window after SCL has fallen, and reads sample at the very end of the high half. Open-drain symbols use one fixed sub-phase length. Push-pull symbols keep SCL high for a fixed four cycles, while the low half stretches with a 2-bit speed grade. The grade is captured together with each command. An idle flag tells the framing layer that no symbol is being played. It says nothing about the state of the bus lines.

Top module: `i3c_bit_modulator`

## Requirements
- R1: During and after a synchronous reset, scl_o is 1, sda_oe is 0, idle and cmd_ready are 1 and rx_valid is 0, including when reset lands in the middle of a symbol.
- R2: A command is taken when cmd_valid and cmd_ready are both 1. cmd_op codes are 0 start, 1 repeated start, 2 stop, 3 push-pull write, 4 open-drain write, 5 push-pull read, 6 open-drain read, 7 hold (lines unchanged for one open-drain symbol time). cmd_ready stays 0 for exactly the symbol length, and any command presented in that time has no effect.
- R3: Start, repeated start, stop, open-drain write and open-drain read each last 64 cycles with default parameters. Their four SCL-low sub-phases total 32 cycles, except start, which keeps SCL high throughout.
- R4: Push-pull write and read symbols last 8, 16, 32 or 64 cycles for pp_grade 0, 1, 2, 3. SCL is low for 4, 12, 28 or 60 of those cycles. pp_grade is sampled only at acceptance.
- R5: A push-pull write drives SDA actively (sda_oe 1, sda_o equal to cmd_bit) for both values and ends with SCL high.
- R6: An open-drain write pulls SDA low (sda_oe 1, sda_o 0) for bit 0 and releases it (sda_oe 0) for bit 1.
- R7: A start keeps SCL high and lowers SDA, ending with SCL high and SDA driven low.
- R8: A stop lowers SDA while SCL is low, raises SCL, then releases SDA while SCL is high, ending with SCL high and SDA released.
- R9: A repeated start releases SDA while SCL is low, so SDA is high when SCL rises, then pulls SDA low while SCL is high.
- R10: Both read symbols release SDA. The SDA level sampled at the last cycle of the symbol appears on rx_data with a single-cycle rx_valid pulse in the cycle after the symbol ends.
- R11: idle is 1 exactly when no symbol is in progress, even while the bus is held with SDA low after a start.
- R12: The SDA line level changes while SCL stays high only during start, repeated start and stop. Data bits change SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Symbol command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 3 | Symbol opcode |
| cmd_bit | input | 1 | Bit value for writes |
| pp_grade | input | 2 | Push-pull speed grade, 0 fastest |
| idle | output | 1 | No symbol in progress |
| rx_valid | output | 1 | One-cycle pulse with a read sample |
| rx_data | output | 1 | Sampled SDA level |
| scl_o | output | 1 | SCL level driven onto the bus |
| sda_o | output | 1 | SDA value when driven |
| sda_oe | output | 1 | SDA drive enable, 0 releases the line |
| sda_i | input | 1 | SDA level seen on the bus |

## Verification
The bench uses the default parameters: eight-cycle open-drain sub-phases, a one-cycle push-pull low unit and one-cycle push-pull high sub-phases. With these values every symbol fits in 64 cycles, so all four speed grades can be compared cycle for cycle against the low-time values in the requirements. Symbols are played back to back in an order where each symbol's hold window inherits a different SDA state. This exercises stop after a driven high, repeated start after a released read, and a grade change in the middle of a symbol.

// File: rtl/i3c_bm_pkg.sv
`timescale 1ns/1ps
package i3c_bm_pkg;

  localparam int PHASES  = 8;
  localparam int PH_W    = $clog2(PHASES);
  localparam int GRADE_W = 2;
  localparam int NGRADES = 1 << GRADE_W;

  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_STOP   = 3'd2,
    OP_WR_PP  = 3'd3,
    OP_WR_OD  = 3'd4,
    OP_RD_PP  = 3'd5,
    OP_RD_OD  = 3'd6,
    OP_HOLD   = 3'd7
  } sym_op_e;

  function automatic logic op_is_od(sym_op_e op);
    return !(op == OP_WR_PP || op == OP_RD_PP);
  endfunction

  function automatic logic op_is_read(sym_op_e op);
    return (op == OP_RD_PP || op == OP_RD_OD);
  endfunction

  function automatic logic op_is_cond(sym_op_e op);
    return (op == OP_START || op == OP_RSTART || op == OP_STOP);
  endfunction

endpackage

// File: rtl/i3c_bm_timer.sv
`timescale 1ns/1ps
module i3c_bm_timer
  import i3c_bm_pkg::*;
#(
  parameter int OD_PHASE_CYC    = 8,
  parameter int PP_LO_UNIT      = 1,
  parameter int PP_HI_PHASE_CYC = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               launch,
  input  logic               od_in,
  input  logic [GRADE_W-1:0] grade_in,
  output logic               busy,
  output logic [PH_W-1:0]    phase,
  output logic               sym_last
);

  localparam int LO_MAX  = PP_LO_UNIT * ((1 << NGRADES) - 1);
  localparam int MAX_A   = (OD_PHASE_CYC > PP_HI_PHASE_CYC) ? OD_PHASE_CYC : PP_HI_PHASE_CYC;
  localparam int MAX_LEN = (MAX_A > LO_MAX) ? MAX_A : LO_MAX;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] OD_M1 = CNT_W'(OD_PHASE_CYC - 1);
  localparam logic [CNT_W-1:0] HI_M1 = CNT_W'(PP_HI_PHASE_CYC - 1);
  localparam logic [PH_W-1:0]  PH_END = PH_W'(PHASES - 1);

  // Low sub-phase length per grade: unit * (2^(g+1) - 1), stored minus one
  logic [CNT_W-1:0] lo_m1 [NGRADES];
  for (genvar g = 0; g < NGRADES; g++) begin : g_grade
    assign lo_m1[g] = CNT_W'(PP_LO_UNIT * ((1 << (g + 1)) - 1) - 1);
  end

  logic               busy_q;
  logic [PH_W-1:0]    phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               od_q;
  logic [GRADE_W-1:0] grade_q;
  logic [CNT_W-1:0]   cur_m1;
  logic               cnt_last;

  always_comb begin
    if (od_q)                 cur_m1 = OD_M1;
    else if (phase_q[PH_W-1]) cur_m1 = HI_M1;
    else                      cur_m1 = lo_m1[grade_q];
  end

  assign cnt_last = (cnt_q == cur_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      phase_q <= '0;
      cnt_q   <= '0;
      od_q    <= 1'b1;
      grade_q <= '0;
    end else if (launch && !busy_q) begin
      busy_q  <= 1'b1;
      phase_q <= '0;
      cnt_q   <= '0;
      od_q    <= od_in;
      grade_q <= grade_in;
    end else if (busy_q) begin
      if (cnt_last) begin
        cnt_q <= '0;
        if (phase_q == PH_END) busy_q  <= 1'b0;
        else                   phase_q <= phase_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy     = busy_q;
  assign phase    = phase_q;
  assign sym_last = busy_q && cnt_last && (phase_q == PH_END);

  // R3/R4: a sub-phase only advances after its full cycle count
  a_r4_phase_on_terminal: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q) && phase_q != $past(phase_q)) |-> $past(cnt_last));

  // R4: mode and grade stay frozen for the whole symbol
  a_r4_grade_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q)) |-> ($stable(grade_q) && $stable(od_q)));

endmodule

// File: rtl/i3c_bm_wave.sv
`timescale 1ns/1ps
module i3c_bm_wave
  import i3c_bm_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            busy,
  input  sym_op_e         op,
  input  logic            bit_val,
  input  logic [PH_W-1:0] phase,
  output logic            scl_o,
  output logic            sda_o,
  output logic            sda_oe
);

  logic scl_q, oe_q, o_q, cond_q;
  logic scl_n, oe_n, o_n;
  logic hi_half;

  assign hi_half = phase[PH_W-1];

  always_comb begin
    scl_n = 1'b1;
    oe_n  = oe_q;
    o_n   = o_q;
    if (busy) begin
      unique case (op)
        OP_START: begin
          if (!hi_half) oe_n = 1'b0;
          else begin oe_n = 1'b1; o_n = 1'b0; end
        end
        OP_RSTART: begin
          scl_n = hi_half;
          if (phase >= PH_W'(2) && phase <= PH_W'(5)) oe_n = 1'b0;
          else if (phase >= PH_W'(6)) begin oe_n = 1'b1; o_n = 1'b0; end
        end
        OP_STOP: begin
          scl_n = hi_half;
          if (phase >= PH_W'(2) && phase <= PH_W'(5)) begin oe_n = 1'b1; o_n = 1'b0; end
          else if (phase >= PH_W'(6)) oe_n = 1'b0;
        end
        OP_WR_PP: begin
          scl_n = hi_half;
          if (phase != '0) begin oe_n = 1'b1; o_n = bit_val; end
        end
        OP_WR_OD: begin
          scl_n = hi_half;
          if (phase != '0) begin oe_n = !bit_val; o_n = 1'b0; end
        end
        OP_RD_PP, OP_RD_OD: begin
          scl_n = hi_half;
          if (phase != '0) oe_n = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q  <= 1'b1;
      oe_q   <= 1'b0;
      o_q    <= 1'b0;
      cond_q <= 1'b0;
    end else begin
      scl_q  <= scl_n;
      oe_q   <= oe_n;
      o_q    <= o_n;
      cond_q <= busy && op_is_cond(op);
    end
  end

  assign scl_o  = scl_q;
  assign sda_o  = o_q;
  assign sda_oe = oe_q;

  logic lvl;
  assign lvl = oe_q ? o_q : 1'b1;

  // R12: SDA moves under a high SCL only for bus conditions
  a_r12_sda_stable_scl_high: assert property (@(posedge clk) disable iff (rst)
    (scl_q && $past(scl_q) && lvl != $past(lvl)) |-> cond_q);

  // R6: an open-drain write of 1 never leaves SDA driven at the end
  a_r6_od_one_released: assert property (@(posedge clk) disable iff (rst)
    (busy && op == OP_WR_OD && bit_val && phase == PH_W'(PHASES - 1)) |=> !oe_q);

endmodule

// File: rtl/i3c_bm_rx.sv
`timescale 1ns/1ps
module i3c_bm_rx (
  input  logic clk,
  input  logic rst,
  input  logic sample_en,
  input  logic sda_i,
  output logic rx_valid,
  output logic rx_data
);

  logic v_q, d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= 1'b0;
      d_q <= 1'b0;
    end else begin
      v_q <= sample_en;
      if (sample_en) d_q <= sda_i;
    end
  end

  assign rx_valid = v_q;
  assign rx_data  = d_q;

  // R10: a read sample is reported as a single-cycle pulse
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    v_q |=> !v_q);

endmodule

// File: rtl/i3c_bit_modulator.sv
`timescale 1ns/1ps
module i3c_bit_modulator
  import i3c_bm_pkg::*;
#(
  parameter int OD_PHASE_CYC    = 8,
  parameter int PP_LO_UNIT      = 1,
  parameter int PP_HI_PHASE_CYC = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [2:0] cmd_op,
  input  logic       cmd_bit,
  input  logic [1:0] pp_grade,
  output logic       idle,
  output logic       rx_valid,
  output logic       rx_data,
  output logic       scl_o,
  output logic       sda_o,
  output logic       sda_oe,
  input  logic       sda_i
);

  logic            busy;
  logic [PH_W-1:0] phase;
  logic            sym_last;
  logic            launch;
  sym_op_e         op_q;
  logic            bit_q;

  assign launch    = cmd_valid && !busy;
  assign cmd_ready = !busy;
  assign idle      = !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q  <= OP_HOLD;
      bit_q <= 1'b0;
    end else if (launch) begin
      op_q  <= sym_op_e'(cmd_op);
      bit_q <= cmd_bit;
    end
  end

  i3c_bm_timer #(
    .OD_PHASE_CYC    (OD_PHASE_CYC),
    .PP_LO_UNIT      (PP_LO_UNIT),
    .PP_HI_PHASE_CYC (PP_HI_PHASE_CYC)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .launch   (launch),
    .od_in    (op_is_od(sym_op_e'(cmd_op))),
    .grade_in (pp_grade),
    .busy     (busy),
    .phase    (phase),
    .sym_last (sym_last)
  );

  i3c_bm_wave u_wave (
    .clk     (clk),
    .rst     (rst),
    .busy    (busy),
    .op      (op_q),
    .bit_val (bit_q),
    .phase   (phase),
    .scl_o   (scl_o),
    .sda_o   (sda_o),
    .sda_oe  (sda_oe)
  );

  i3c_bm_rx u_rx (
    .clk       (clk),
    .rst       (rst),
    .sample_en (sym_last && op_is_read(op_q)),
    .sda_i     (sda_i),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data)
  );

  // R2: an accepted command closes the handshake on the next cycle
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> (!cmd_ready && !idle));

  // R11: without a command the block stays idle
  a_r11_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (idle && !cmd_valid) |=> idle);

  // R10: read results come only from read symbols
  a_r10_rx_after_read: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ($past(busy) && op_is_read(op_q)));

endmodule

// File: tb/test_i3c_bit_modulator.sv
`timescale 1ns/1ps
module test_i3c_bit_modulator;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_op = 3'd0;
  logic       cmd_bit = 1'b0;
  logic [1:0] pp_grade = 2'd0;
  logic       idle, rx_valid, rx_data, scl_o, sda_o, sda_oe;
  logic       sda_i = 1'b1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  i3c_bit_modulator i_i3c_bit_modulator (
    .clk (clk), .rst (rst), .cmd_valid (cmd_valid), .cmd_ready (cmd_ready),
    .cmd_op (cmd_op), .cmd_bit (cmd_bit), .pp_grade (pp_grade), .idle (idle),
    .rx_valid (rx_valid), .rx_data (rx_data), .scl_o (scl_o), .sda_o (sda_o),
    .sda_oe (sda_oe), .sda_i (sda_i)
  );

  // rise: SDA level at SCL rise (2 = no rise expected); rx: 2 = no read pulse
  typedef struct packed {
    logic [2:0] op;
    logic       bt;
    logic [1:0] gr;
    logic       sin;
    logic [6:0] ncyc;
    logic [6:0] nlow;
    logic       foe;
    logic       fo;
    logic [1:0] rise;
    logic [1:0] rx;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{3'd0, 1'b0, 2'd0, 1'b1, 7'd64, 7'd0,  1'b1, 1'b0, 2'd2, 2'd2},
    '{3'd3, 1'b1, 2'd0, 1'b1, 7'd8,  7'd4,  1'b1, 1'b1, 2'd1, 2'd2},
    '{3'd3, 1'b0, 2'd1, 1'b1, 7'd16, 7'd12, 1'b1, 1'b0, 2'd0, 2'd2},
    '{3'd3, 1'b1, 2'd2, 1'b1, 7'd32, 7'd28, 1'b1, 1'b1, 2'd1, 2'd2},
    '{3'd3, 1'b0, 2'd3, 1'b1, 7'd64, 7'd60, 1'b1, 1'b0, 2'd0, 2'd2},
    '{3'd4, 1'b1, 2'd0, 1'b1, 7'd64, 7'd32, 1'b0, 1'b0, 2'd1, 2'd2},
    '{3'd4, 1'b0, 2'd0, 1'b1, 7'd64, 7'd32, 1'b1, 1'b0, 2'd0, 2'd2},
    '{3'd6, 1'b0, 2'd0, 1'b0, 7'd64, 7'd32, 1'b0, 1'b0, 2'd1, 2'd0},
    '{3'd5, 1'b0, 2'd0, 1'b1, 7'd8,  7'd4,  1'b0, 1'b0, 2'd1, 2'd1},
    '{3'd5, 1'b0, 2'd3, 1'b0, 7'd64, 7'd60, 1'b0, 1'b0, 2'd1, 2'd0},
    '{3'd1, 1'b0, 2'd0, 1'b1, 7'd64, 7'd32, 1'b1, 1'b0, 2'd1, 2'd2},
    '{3'd6, 1'b0, 2'd0, 1'b1, 7'd64, 7'd32, 1'b0, 1'b0, 2'd1, 2'd1},
    '{3'd3, 1'b1, 2'd1, 1'b1, 7'd16, 7'd12, 1'b1, 1'b1, 2'd1, 2'd2},
    '{3'd2, 1'b0, 2'd0, 1'b1, 7'd64, 7'd32, 1'b0, 1'b0, 2'd0, 2'd2}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string tag_of(logic [2:0] op);
    case (op)
      3'd0: return "R7";
      3'd1: return "R9";
      3'd2: return "R8";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R10";
    endcase
  endfunction

  // Plays one symbol; junk > 0 keeps a stop command offered for that many busy cycles
  task automatic run_vec(vec_t v, int junk);
    int    nbusy = 0;
    int    nlow  = 0;
    int    nrx   = 0;
    int    rxval = 0;
    int    rise  = 2;
    int    hichg = 0;
    int    fin   = 0;
    logic  prev_scl, prev_lvl, lvl;
    string tg  = tag_of(v.op);
    string ttg = (v.op == 3'd3 || v.op == 3'd5) ? "R4" : "R3";
    @(negedge clk);
    cmd_op = v.op; cmd_bit = v.bt; pp_grade = v.gr; sda_i = v.sin; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    pp_grade  = ~v.gr;            // R4: must not affect the running symbol
    prev_scl = scl_o;
    prev_lvl = sda_oe ? sda_o : 1'b1;
    for (int k = 0; k < 200; k++) begin
      lvl = sda_oe ? sda_o : 1'b1;
      if (!cmd_ready) nbusy++;
      if (rx_valid) begin nrx++; rxval = int'(rx_data); end
      if (k > 0) begin
        if (!scl_o) nlow++;
        if (!prev_scl && scl_o && rise == 2) rise = int'(lvl);
        if (prev_scl && scl_o && lvl != prev_lvl) hichg++;
      end
      prev_scl = scl_o;
      prev_lvl = lvl;
      if (k > 0 && cmd_ready) begin fin = 1; break; end
      if (k < junk) begin cmd_valid = 1'b1; cmd_op = 3'd2; end
      else cmd_valid = 1'b0;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    check({ttg, " symbol cycles"}, nbusy, int'(v.ncyc));
    check({ttg, " SCL low cycles"}, nlow, int'(v.nlow));
    check({tg, " final SCL"}, int'(scl_o), 1);
    check({tg, " final SDA oe"}, int'(sda_oe), int'(v.foe));
    if (v.foe) check({tg, " final SDA value"}, int'(sda_o), int'(v.fo));
    check("R11 idle after symbol", int'(idle), fin);
    if (v.rise != 2'd2) check({tg, " SDA at SCL rise"}, rise, int'(v.rise));
    check("R12 SDA changes under high SCL", hichg,
          (v.op == 3'd0 || v.op == 3'd1 || v.op == 3'd2) ? 1 : 0);
    if (v.rx == 2'd2) check("R10 no read pulse", nrx, 0);
    else begin
      check("R10 read pulse count", nrx, 1);
      check("R10 read value", rxval, int'(v.rx));
    end
  endtask

  task automatic check_reset_state(string ctx);
    check({"R1 scl ", ctx}, int'(scl_o), 1);
    check({"R1 sda_oe ", ctx}, int'(sda_oe), 0);
    check({"R1 idle ", ctx}, int'(idle), 1);
    check({"R1 cmd_ready ", ctx}, int'(cmd_ready), 1);
    check({"R1 rx_valid ", ctx}, int'(rx_valid), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check_reset_state("in reset");
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check_reset_state("after reset");

    for (int i = 0; i < NV; i++) run_vec(VT[i], 0);

    // R2: a command offered while busy is ignored (no stop appears)
    run_vec('{3'd3, 1'b1, 2'd1, 1'b1, 7'd16, 7'd12, 1'b1, 1'b1, 2'd1, 2'd2}, 10);
    repeat (3) @(negedge clk);
    check("R2 no extra symbol", int'(cmd_ready), 1);
    check("R2 SDA still driven high", int'(sda_oe && sda_o), 1);

    // R1: reset in the middle of a slow push-pull write
    @(negedge clk);
    cmd_op = 3'd3; cmd_bit = 1'b0; pp_grade = 2'd3; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (20) @(negedge clk);
    check("R1 symbol running before reset", int'(cmd_ready), 0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state("mid-symbol");
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check_reset_state("after mid-symbol reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2: watchdog expired, actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule